// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many clock cycles and keeps its results in a dedicated pair of result registers, HI and LO, that sit outside the general register file. A command selects one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. The block then iterates one bit per cycle and holds `busy` high until the last iteration writes the result pair. A multiply leaves the upper half of its 64-bit product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. No operation raises an exception.

The surrounding pipeline reads HI or LO through a read port. The read port reports `rd_valid` only while the unit is idle, so a read made during a computation waits until the result is committed. Either register can also be loaded directly through a write port. These moves are complete operations in their own right: they are how results reach general registers and how HI and LO are saved and restored.

Top module: `muldiv_hilo`

## Requirements
- R1: With `op` = 2'b00 (signed multiply), the operands are taken as two's complement. Afterwards HI holds bits 63..32 and LO holds bits 31..0 of the 64-bit signed product.
- R2: With `op` = 2'b01 (unsigned multiply), the operands are taken as unsigned. Afterwards HI:LO holds the 64-bit unsigned product.
- R3: A `start` sampled while `busy` is low is accepted. `busy` is then high for exactly 32 cycles, and HI/LO hold the new result in the cycle where `busy` first reads low. A `start` sampled while `busy` is high is ignored.
- R4: With `op` = 2'b10 (signed divide), LO receives the quotient truncated toward zero and HI receives the remainder, which carries the sign of the dividend. The case -2^31 / -1 gives LO = 32'h8000_0000 and HI = 0, with no exception.
- R5: With `op` = 2'b11 (unsigned divide), LO receives the unsigned quotient and HI receives the unsigned remainder.
- R6: A zero divisor completes in the normal time without a trap, and HI receives the dividend. For the unsigned divide, LO is all ones. For the signed divide, LO is all ones when the dividend is non-negative and 1 when it is negative.
- R7: `rd_valid` equals `rd_req` while `busy` is low and is 0 while `busy` is high. `rd_data` shows HI when `rd_sel` = 1 and LO when `rd_sel` = 0.
- R8: While `busy` is low, `wr_hi` / `wr_lo` load `wr_data` into HI / LO, and the new value is readable from the next cycle on. While `busy` is high, these writes are ignored.
- R9: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation |
| op | input | 2 | Operation select: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand / dividend |
| opb | input | 32 | Multiplier / divisor |
| busy | output | 1 | Computation in progress |
| wr_hi | input | 1 | Load HI from `wr_data` |
| wr_lo | input | 1 | Load LO from `wr_data` |
| wr_data | input | 32 | Value for a direct load |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | Read select: 1 HI, 0 LO |
| rd_data | output | 32 | Selected register contents |
| rd_valid | output | 1 | Read is served this cycle |

## Verification
The assertions on write behaviour assume that `wr_data`, `wr_hi` and `wr_lo` are settled before each sampling edge. The bench meets this by driving every input on the falling edge. The busy-length assertion assumes that the operation is never restarted while busy. The bench still raises `start` mid-computation, but only to show that such a start is ignored. Zero divisors with a signed operation are applied only with the dividend signs listed in R6, which keeps the reference values well defined.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;
endpackage

// File: rtl/md_mul_step.sv
// One shift-add iteration: conditionally add the multiplicand into the
// upper half, then shift the {acc,q} pair right by one.
module md_mul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] q,
  input  logic [W-1:0] m,
  output logic [W-1:0] acc_n,
  output logic [W-1:0] q_n
);
  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, acc} + (q[0] ? {1'b0, m} : '0);
    acc_n = sum[W:1];
    q_n   = {sum[0], q[W-1:1]};
  end
endmodule

// File: rtl/md_div_step.sv
// One restoring-division iteration: shift the next dividend bit into the
// partial remainder and subtract the divisor when it fits.
module md_div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] q,
  input  logic [W-1:0] m,
  output logic [W-1:0] acc_n,
  output logic [W-1:0] q_n
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {acc, q[W-1]};
    fits    = (shifted >= {1'b0, m});
    diff    = shifted - {1'b0, m};
    acc_n   = fits ? diff[W-1:0] : shifted[W-1:0];
    q_n     = {q[W-2:0], fits};
  end
endmodule

// File: rtl/md_sign_fix.sv
// Applies the sign correction to magnitude results at commit time.
module md_sign_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         flip_lo,
  input  logic         flip_hi,
  input  logic [W-1:0] hi_raw,
  input  logic [W-1:0] lo_raw,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out
);
  localparam int DW = 2 * W;
  logic [DW-1:0] prod;

  always_comb begin
    prod = {hi_raw, lo_raw};
    if (is_div) begin
      lo_out = flip_lo ? (~lo_raw + 1'b1) : lo_raw;
      hi_out = flip_hi ? (~hi_raw + 1'b1) : hi_raw;
    end else begin
      if (flip_lo) prod = ~prod + 1'b1;
      hi_out = prod[DW-1:W];
      lo_out = prod[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  import muldiv_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] ITERS = CW'(W);

  // architectural and working state
  logic [W-1:0]  hi_q, lo_q, acc_q, qr_q, m_q;
  logic [W-1:0]  hi_d, lo_d, acc_d, qr_d, m_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          is_div_q, is_div_d, flip_lo_q, flip_lo_d, flip_hi_q, flip_hi_d;
  logic          hi_en, lo_en, work_en;

  // iteration datapath
  logic [W-1:0] mul_acc, mul_q, div_acc, div_q, step_acc, step_q;
  logic [W-1:0] fix_hi, fix_lo;

  md_mul_step #(.W(W)) u_mul (
    .acc(acc_q), .q(qr_q), .m(m_q), .acc_n(mul_acc), .q_n(mul_q)
  );
  md_div_step #(.W(W)) u_div (
    .acc(acc_q), .q(qr_q), .m(m_q), .acc_n(div_acc), .q_n(div_q)
  );

  assign step_acc = is_div_q ? div_acc : mul_acc;
  assign step_q   = is_div_q ? div_q   : mul_q;

  md_sign_fix #(.W(W)) u_fix (
    .is_div(is_div_q), .flip_lo(flip_lo_q), .flip_hi(flip_hi_q),
    .hi_raw(step_acc), .lo_raw(step_q), .hi_out(fix_hi), .lo_out(fix_lo)
  );

  // operand decode
  logic         accept, last, sgn, neg_a, neg_b;
  logic [W-1:0] mag_a, mag_b;

  always_comb begin
    accept = start && !busy_q;
    last   = busy_q && (cnt_q == CW'(1));
    sgn    = (op == OP_MULS) || (op == OP_DIVS);
    neg_a  = sgn && opa[W-1];
    neg_b  = sgn && opb[W-1];
    mag_a  = neg_a ? (~opa + 1'b1) : opa;
    mag_b  = neg_b ? (~opb + 1'b1) : opb;
  end

  // next-state logic
  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    is_div_d  = is_div_q;
    flip_lo_d = flip_lo_q;
    flip_hi_d = flip_hi_q;
    acc_d     = acc_q;
    qr_d      = qr_q;
    m_d       = m_q;
    hi_d      = hi_q;
    lo_d      = lo_q;
    hi_en     = 1'b0;
    lo_en     = 1'b0;
    work_en   = 1'b0;

    if (accept) begin
      work_en   = 1'b1;
      busy_d    = 1'b1;
      cnt_d     = ITERS;
      is_div_d  = op[1];
      flip_lo_d = neg_a ^ neg_b;
      flip_hi_d = neg_a;
      acc_d     = '0;
      qr_d      = mag_a;
      m_d       = mag_b;
    end else if (busy_q) begin
      work_en = 1'b1;
      cnt_d   = cnt_q - CW'(1);
      acc_d   = step_acc;
      qr_d    = step_q;
      if (last) begin
        busy_d = 1'b0;
        hi_d   = fix_hi;
        lo_d   = fix_lo;
        hi_en  = 1'b1;
        lo_en  = 1'b1;
      end
    end

    if (!busy_q) begin
      if (wr_hi) begin
        hi_d  = wr_data;
        hi_en = 1'b1;
      end
      if (wr_lo) begin
        lo_d  = wr_data;
        lo_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      qr_q      <= '0;
      m_q       <= '0;
      is_div_q  <= 1'b0;
      flip_lo_q <= 1'b0;
      flip_hi_q <= 1'b0;
    end else if (work_en) begin
      acc_q     <= acc_d;
      qr_q      <= qr_d;
      m_q       <= m_d;
      is_div_q  <= is_div_d;
      flip_lo_q <= flip_lo_d;
      flip_hi_q <= flip_hi_d;
    end
  end

  // outputs
  assign busy     = busy_q;
  assign rd_valid = rd_req && !busy_q;
  assign rd_data  = rd_sel ? hi_q : lo_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         rd_req,
  input logic         rd_valid,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (!busy) bcnt <= '0;
    else bcnt <= bcnt + CW'(1);
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == CW'(W)));

  assert_read_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);

  assert_read_serve_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |-> rd_valid);

  assert_move_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_hi) |=> (hi_q == $past(wr_data)));

  assert_move_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_lo) |=> (lo_q == $past(wr_data)));

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(hi_q) && $stable(lo_q))));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_valid(rd_valid),
  .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] opa = '0, opb = '0, wr_data = '0;
  logic         wr_hi = 1'b0, wr_lo = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
  logic         busy, rd_valid;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_hilo #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle-by-cycle busy model (R3): accepts start only when idle
  bit m_busy = 1'b0;
  int m_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= 0;
    end else if (!m_busy && start) begin
      m_busy <= 1'b1;
      m_cnt  <= W;
    end else if (m_busy) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) m_busy <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) check("R3 busy per-cycle", {63'b0, busy}, {63'b0, m_busy});
  end

  task automatic read_reg(input bit sel, output logic [W-1:0] v, output logic vld);
    @(negedge clk);
    rd_req = 1'b1;
    rd_sel = sel;
    #1;
    v   = rd_data;
    vld = rd_valid;
    rd_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic run_op(string req, logic [1:0] o, logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] exp_hi, logic [W-1:0] exp_lo);
    logic [W-1:0] v;
    logic vld;
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    read_reg(1'b1, v, vld);
    check({req, " HI"}, {32'b0, v}, {32'b0, exp_hi});
    check({req, " HI valid"}, {63'b0, vld}, 64'd1);
    read_reg(1'b0, v, vld);
    check({req, " LO"}, {32'b0, v}, {32'b0, exp_lo});
  endtask

  task automatic mul_s(logic [W-1:0] a, logic [W-1:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    run_op("R1 signed mul", 2'b00, a, b, p[63:32], p[31:0]);
  endtask

  task automatic mul_u(logic [W-1:0] a, logic [W-1:0] b);
    logic [63:0] p;
    p = {32'b0, a} * {32'b0, b};
    run_op("R2 unsigned mul", 2'b01, a, b, p[63:32], p[31:0]);
  endtask

  task automatic div_s(logic [W-1:0] a, logic [W-1:0] b);
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    q = sa / sb;
    r = sa % sb;
    run_op("R4 signed div", 2'b10, a, b, r[31:0], q[31:0]);
  endtask

  task automatic div_u(logic [W-1:0] a, logic [W-1:0] b);
    run_op("R5 unsigned div", 2'b11, a, b, a % b, a / b);
  endtask

  initial begin
    logic [W-1:0] v;
    logic vld;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check("R9 busy after reset", {63'b0, busy}, 64'd0);
    read_reg(1'b1, v, vld);
    check("R9 HI after reset", {32'b0, v}, 64'd0);
    read_reg(1'b0, v, vld);
    check("R9 LO after reset", {32'b0, v}, 64'd0);

    // R8 direct moves while idle, readable next cycle
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 32'hCAFE_0001;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h1234_5678;
    @(negedge clk);
    wr_lo = 1'b0;
    read_reg(1'b1, v, vld);
    check("R8 move to HI", {32'b0, v}, 64'hCAFE_0001);
    read_reg(1'b0, v, vld);
    check("R8 move to LO", {32'b0, v}, 64'h1234_5678);
    check("R7 valid when idle", {63'b0, vld}, 64'd1);

    // R1 signed multiply
    mul_s(32'd7, 32'd6);
    mul_s(32'hFFFF_FFFD, 32'd5);
    mul_s(32'h8000_0000, 32'h8000_0000);
    mul_s(32'h8000_0000, 32'h7FFF_FFFF);
    mul_s(32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R2 unsigned multiply
    mul_u(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    mul_u(32'h1234_5678, 32'h9ABC_DEF0);
    mul_u(32'd0, 32'hDEAD_BEEF);

    // R4 signed divide
    div_s(32'd100, 32'd7);
    div_s(32'hFFFF_FF9C, 32'd7);
    div_s(32'd100, 32'hFFFF_FFF9);
    div_s(32'hFFFF_FF9C, 32'hFFFF_FFF9);
    run_op("R4 min by minus one", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000);

    // R5 unsigned divide
    div_u(32'hFFFF_FFFF, 32'd10);
    div_u(32'd5, 32'd9);
    div_u(32'h8000_0000, 32'h8000_0000);

    // R6 divide by zero
    run_op("R6 unsigned div0", 2'b11, 32'hABCD_0123, 32'd0, 32'hABCD_0123, 32'hFFFF_FFFF);
    run_op("R6 signed div0 pos", 2'b10, 32'd77, 32'd0, 32'd77, 32'hFFFF_FFFF);
    run_op("R6 signed div0 neg", 2'b10, 32'hFFFF_FFF0, 32'd0, 32'hFFFF_FFF0, 32'd1);

    // R3/R7/R8 during a computation: restart, stalled read and moves ignored
    @(negedge clk);
    start = 1'b1; op = 2'b01; opa = 32'd1000; opb = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; op = 2'b11; opa = 32'd9; opb = 32'd2;
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h5555_AAAA;
    rd_req = 1'b1; rd_sel = 1'b1;
    #1;
    check("R7 read stalled while busy", {63'b0, rd_valid}, 64'd0);
    @(negedge clk);
    start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; rd_req = 1'b0;
    wait_idle();
    read_reg(1'b1, v, vld);
    check("R8 HI write ignored while busy / R3 restart ignored", {32'b0, v}, 64'd0);
    read_reg(1'b0, v, vld);
    check("R8 LO write ignored while busy / R3 restart ignored", {32'b0, v}, 64'd3000);

    // R3 exact busy length of a single accepted start
    @(negedge clk);
    start = 1'b1; op = 2'b00; opa = 32'd3; opb = 32'd3;
    @(negedge clk);
    start = 1'b0;
    begin
      int n;
      n = 0;
      while (busy && n < 100) begin
        n++;
        @(negedge clk);
      end
      check("R3 busy length", 64'(n), 64'd32);
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    done = 1'b1;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule